// File: doc/BRIEF.md
# Protection Debounce and Latch Supervisor

This block decides whether a flyback power stage may switch. It takes digital flags from analog comparators: supply over-voltage, two thermal levels (warning and critical), feedback stuck high (open control loop), and current-sense input stuck low while the switch is on. It also takes four supply-level flags that mark the turn-on, turn-off, discharge-stop and latch-release levels. Every fault flag must stay asserted for its own time before it counts. All timers count a one-microsecond strobe, `tick_1us`. A drop of the flag before that time clears the count.

A qualified fault shuts the stage down in one of two ways. A latched shutdown holds `pwm_en` low until the supply collapses below the latch-release level. An auto-restart shutdown waits for the supply to fall below the turn-off level. It then raises `discharge_req` to pull the supply down to the discharge-stop level, and waits for the turn-on level again. This two-level cycle also follows an ordinary undervoltage during operation. Every new start gives a soft-start window on `soft_start`. `fault_cause` reports which fault caused the most recent fault shutdown.

There are no data streams in this block. Every pin is a plain level and has no valid/ready handshake, so there is no back-pressure.

Top module: `prot_supervisor`

## Requirements
- R1: After reset, `pwm_en`, `discharge_req` and `soft_start` are 0 and `fault_cause` is 0. `pwm_en` rises only in the cycle after `vdd_ge_on` has been seen high.
- R2: Supply over-voltage trips when `ovp_flag` stays high for TICKS_OV ticks, with a shutdown one clock later. The shutdown is latched: it holds with no discharge request until `vdd_ge_rel` falls, and a restart then needs `vdd_ge_on`.
- R3: A thermal warning trips when `hot_warn_flag` stays high for TICKS_HOT ticks, or for TICKS_HOT_LL ticks while `light_load` is 1. The shutdown is latched.
- R4: A critical thermal fault trips when `hot_crit_flag` stays high for TICKS_CRIT ticks, or for TICKS_CRIT_LL ticks while `light_load` is 1. The shutdown is latched.
- R5: An open control loop trips when `fb_high_flag` stays high for TICKS_OPEN ticks. The shutdown is latched when `open_loop_latch` is 1 and auto-restart when it is 0.
- R6: `sense_low_flag` is sampled only once per switch pulse: at the tick where the gate on-time reaches TICKS_ARM. A shorted sense input trips once that sample has stayed low for TICKS_SHORT further ticks. The shutdown is auto-restart. A high sample restarts the count, and a low sense level outside the sample point is ignored.
- R7: Any debounce count returns to zero when its flag drops before the time is reached. The next qualification then needs the full time again.
- R8: After an auto-restart shutdown, `pwm_en` stays 0. `discharge_req` rises once `vdd_ge_off` is low and falls once `vdd_ge_sink` is low. The next start needs `vdd_ge_on`. `discharge_req` and `pwm_en` are never both 1.
- R9: If `vdd_ge_off` falls while running, the same discharge-and-restart cycle follows, and `fault_cause` keeps its value.
- R10: On every entry into operation, `soft_start` is 1 for exactly TICKS_SOFT ticks, and only while `pwm_en` is 1.
- R11: `fault_cause` codes are 1 = over-voltage, 2 = thermal (either level), 3 = shorted sense, 4 = open loop. The value changes only when a fault shutdown happens. When several faults qualify in the same cycle, the priority order is over-voltage, then thermal, then shorted sense, then open loop, and the response of the winning fault applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| tick_1us | input | 1 | One-cycle strobe every microsecond; all timers count it |
| ovp_flag | input | 1 | Supply above the over-voltage threshold |
| hot_warn_flag | input | 1 | Thermal sense below the warning threshold |
| hot_crit_flag | input | 1 | Thermal sense below the critical threshold |
| fb_high_flag | input | 1 | Feedback above the open-loop threshold |
| sense_low_flag | input | 1 | Current-sense input below the short threshold |
| gate_on | input | 1 | Power switch is currently driven on |
| light_load | input | 1 | Light-load operation; selects the longer thermal delays |
| open_loop_latch | input | 1 | 1: open loop latches off; 0: open loop auto-restarts |
| vdd_ge_on | input | 1 | Supply at or above the turn-on level |
| vdd_ge_off | input | 1 | Supply at or above the turn-off level |
| vdd_ge_sink | input | 1 | Supply at or above the discharge-stop level |
| vdd_ge_rel | input | 1 | Supply at or above the latch-release level |
| pwm_en | output | 1 | Switching allowed |
| discharge_req | output | 1 | Request for the supply discharge sink |
| soft_start | output | 1 | Soft-start window active |
| fault_cause | output | 3 | Cause of the most recent fault shutdown (codes in R11) |

## Verification
The assertions assume that the four supply flags are nested: a higher level implies every lower one. They also assume that `tick_1us` is a clean strobe, and that a fault flag which qualified stays up for the clock in which the shutdown is decided. The bench moves the supply flags only in nested steps (turn-on and turn-off fall together, and the discharge-stop and release levels follow later). It holds each fault flag until the shutdown has been observed. It drives `tick_1us` high every cycle, so every expected cycle count comes straight from the tick parameters.

// File: rtl/prot_sup_pkg.sv
package prot_sup_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_OVERV = 3'd1,
    CAUSE_THERM = 3'd2,
    CAUSE_SHORT = 3'd3,
    CAUSE_OPEN  = 3'd4
  } cause_e;

  typedef enum logic [2:0] {
    ST_WAIT_ON = 3'd0,
    ST_RUN     = 3'd1,
    ST_HOLD    = 3'd2,
    ST_DRAIN   = 3'd3,
    ST_LATCH   = 3'd4
  } sup_state_e;

  // fault slot indices of the debounce bank
  localparam int F_OVERV = 0;
  localparam int F_WARN  = 1;
  localparam int F_CRIT  = 2;
  localparam int F_OPEN  = 3;
  localparam int F_SHORT = 4;
  localparam int NFAULT  = 5;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prot_sup_debounce.sv
module prot_sup_debounce #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          flag,
  input  logic [CW-1:0] limit,
  output logic          trip
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr || !flag)
      cnt <= '0;
    else if (tick && (cnt < limit))
      cnt <= cnt + 1'b1;
  end

  assign trip = flag && (cnt >= limit);
endmodule

// File: rtl/prot_sup_short_arm.sv
module prot_sup_short_arm #(
  parameter int ARM_TICKS = 4,
  localparam int AW = $clog2(ARM_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic gate_on,
  input  logic sense_low,
  output logic seen_low
);
  logic [AW-1:0] on_cnt;
  logic          sample_pt;

  assign sample_pt = gate_on && tick && (on_cnt == AW'(ARM_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      on_cnt <= '0;
    else if (clr || !gate_on)
      on_cnt <= '0;
    else if (tick && (on_cnt < AW'(ARM_TICKS)))
      on_cnt <= on_cnt + 1'b1;
  end

  // the sample holds across the off time so pulses chain together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_low <= 1'b0;
    else if (clr)
      seen_low <= 1'b0;
    else if (sample_pt)
      seen_low <= sense_low;
  end
endmodule

// File: rtl/prot_sup_softstart.sv
module prot_sup_softstart #(
  parameter int SOFT_TICKS = 8000,
  localparam int SW = $clog2(SOFT_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic active
);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run)
      cnt <= '0;
    else if (tick && (cnt < SW'(SOFT_TICKS)))
      cnt <= cnt + 1'b1;
  end

  assign active = run && (cnt < SW'(SOFT_TICKS));
endmodule

// File: rtl/prot_sup_ctrl.sv
module prot_sup_ctrl
  import prot_sup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFAULT-1:0] trip,
  input  logic              open_loop_latch,
  input  logic              vdd_ge_on,
  input  logic              vdd_ge_off,
  input  logic              vdd_ge_sink,
  input  logic              vdd_ge_rel,
  output sup_state_e        state,
  output cause_e            cause
);
  cause_e     win_cause;
  logic       win_latch;
  logic       any_trip;
  sup_state_e state_nx;

  // fixed priority: over-voltage, thermal, shorted sense, open loop
  always_comb begin
    win_cause = CAUSE_NONE;
    win_latch = 1'b0;
    if (trip[F_OVERV]) begin
      win_cause = CAUSE_OVERV;
      win_latch = 1'b1;
    end else if (trip[F_WARN] || trip[F_CRIT]) begin
      win_cause = CAUSE_THERM;
      win_latch = 1'b1;
    end else if (trip[F_SHORT]) begin
      win_cause = CAUSE_SHORT;
      win_latch = 1'b0;
    end else if (trip[F_OPEN]) begin
      win_cause = CAUSE_OPEN;
      win_latch = open_loop_latch;
    end
  end

  assign any_trip = |trip;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_WAIT_ON: if (vdd_ge_on) state_nx = ST_RUN;
      ST_RUN: begin
        if (any_trip)
          state_nx = win_latch ? ST_LATCH : ST_HOLD;
        else if (!vdd_ge_off)
          state_nx = ST_DRAIN;
      end
      ST_HOLD:  if (!vdd_ge_off)  state_nx = ST_DRAIN;
      ST_DRAIN: if (!vdd_ge_sink) state_nx = ST_WAIT_ON;
      ST_LATCH: if (!vdd_ge_rel)  state_nx = ST_WAIT_ON;
      default:  state_nx = ST_WAIT_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAIT_ON;
      cause <= CAUSE_NONE;
    end else begin
      state <= state_nx;
      if ((state == ST_RUN) && any_trip)
        cause <= win_cause;
    end
  end
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_sup_pkg::*;
#(
  parameter int TICKS_OV      = 165,
  parameter int TICKS_HOT     = 16000,
  parameter int TICKS_HOT_LL  = 51000,
  parameter int TICKS_CRIT    = 185,
  parameter int TICKS_CRIT_LL = 605,
  parameter int TICKS_OPEN    = 56000,
  parameter int TICKS_ARM     = 4,
  parameter int TICKS_SHORT   = 120,
  parameter int TICKS_SOFT    = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       ovp_flag,
  input  logic       hot_warn_flag,
  input  logic       hot_crit_flag,
  input  logic       fb_high_flag,
  input  logic       sense_low_flag,
  input  logic       gate_on,
  input  logic       light_load,
  input  logic       open_loop_latch,
  input  logic       vdd_ge_on,
  input  logic       vdd_ge_off,
  input  logic       vdd_ge_sink,
  input  logic       vdd_ge_rel,
  output logic       pwm_en,
  output logic       discharge_req,
  output logic       soft_start,
  output logic [2:0] fault_cause
);
  localparam int TMAX = imax(imax(imax(TICKS_OV, TICKS_HOT), imax(TICKS_HOT_LL, TICKS_CRIT)),
                             imax(imax(TICKS_CRIT_LL, TICKS_OPEN), TICKS_SHORT));
  localparam int CW = $clog2(TMAX + 1);

  sup_state_e        state;
  cause_e            cause;
  logic              running;
  logic              short_seen;
  logic [NFAULT-1:0] flg;
  logic [NFAULT-1:0] trip;
  logic [CW-1:0]     lim [NFAULT];

  assign running = (state == ST_RUN);

  assign flg[F_OVERV] = ovp_flag;
  assign flg[F_WARN]  = hot_warn_flag;
  assign flg[F_CRIT]  = hot_crit_flag;
  assign flg[F_OPEN]  = fb_high_flag;
  assign flg[F_SHORT] = short_seen;

  assign lim[F_OVERV] = CW'(TICKS_OV);
  assign lim[F_WARN]  = light_load ? CW'(TICKS_HOT_LL)  : CW'(TICKS_HOT);
  assign lim[F_CRIT]  = light_load ? CW'(TICKS_CRIT_LL) : CW'(TICKS_CRIT);
  assign lim[F_OPEN]  = CW'(TICKS_OPEN);
  assign lim[F_SHORT] = CW'(TICKS_SHORT);

  prot_sup_short_arm #(.ARM_TICKS(TICKS_ARM)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!running),
    .tick      (tick_1us),
    .gate_on   (gate_on),
    .sense_low (sense_low_flag),
    .seen_low  (short_seen)
  );

  for (genvar g = 0; g < NFAULT; g++) begin : g_deb
    prot_sup_debounce #(.CW(CW)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!running),
      .tick  (tick_1us),
      .flag  (flg[g]),
      .limit (lim[g]),
      .trip  (trip[g])
    );
  end

  prot_sup_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .trip            (trip),
    .open_loop_latch (open_loop_latch),
    .vdd_ge_on       (vdd_ge_on),
    .vdd_ge_off      (vdd_ge_off),
    .vdd_ge_sink     (vdd_ge_sink),
    .vdd_ge_rel      (vdd_ge_rel),
    .state           (state),
    .cause           (cause)
  );

  prot_sup_softstart #(.SOFT_TICKS(TICKS_SOFT)) u_soft (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (running),
    .tick   (tick_1us),
    .active (soft_start)
  );

  assign pwm_en        = running;
  assign discharge_req = (state == ST_DRAIN);
  assign fault_cause   = cause;
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovp_flag,
  input logic       hot_warn_flag,
  input logic       hot_crit_flag,
  input logic       fb_high_flag,
  input logic       vdd_ge_on,
  input logic       vdd_ge_off,
  input logic       vdd_ge_sink,
  input logic       pwm_en,
  input logic       discharge_req,
  input logic       soft_start,
  input logic [2:0] fault_cause
);
  a_r1_start_needs_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> $past(vdd_ge_on));

  a_r8_sink_starts_below_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discharge_req) |-> $past(!vdd_ge_off));

  a_r8_sink_stops_at_level: assert property (@(posedge clk) disable iff (!rst_n)
    (discharge_req && !vdd_ge_sink) |=> !discharge_req);

  a_r8_sink_excludes_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_en && discharge_req));

  a_r10_soft_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |-> pwm_en);

  a_r11_cause_moves_on_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_cause) |-> $fell(pwm_en));

  a_r7_cause_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fault_cause) && (fault_cause != 3'd3)) |->
      $past(ovp_flag || hot_warn_flag || hot_crit_flag || fb_high_flag));
endmodule

bind prot_supervisor prot_supervisor_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ovp_flag      (ovp_flag),
  .hot_warn_flag (hot_warn_flag),
  .hot_crit_flag (hot_crit_flag),
  .fb_high_flag  (fb_high_flag),
  .vdd_ge_on     (vdd_ge_on),
  .vdd_ge_off    (vdd_ge_off),
  .vdd_ge_sink   (vdd_ge_sink),
  .pwm_en        (pwm_en),
  .discharge_req (discharge_req),
  .soft_start    (soft_start),
  .fault_cause   (fault_cause)
);

// File: tb/prot_supervisor_tb_top.sv
`timescale 1ns/1ps
module prot_supervisor_tb_top;
  localparam int P_OV = 6, P_HOT = 20, P_HOT_LL = 40, P_CRIT = 5, P_CRIT_LL = 12;
  localparam int P_OPEN = 30, P_ARM = 3, P_SHORT = 10, P_SOFT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1us = 1'b1;
  logic ovp_flag = 0, hot_warn_flag = 0, hot_crit_flag = 0, fb_high_flag = 0;
  logic sense_low_flag = 0, gate_on = 0, light_load = 0, open_loop_latch = 0;
  logic vdd_ge_on = 0, vdd_ge_off = 0, vdd_ge_sink = 0, vdd_ge_rel = 0;
  logic pwm_en, discharge_req, soft_start;
  logic [2:0] fault_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prot_supervisor #(
    .TICKS_OV(P_OV), .TICKS_HOT(P_HOT), .TICKS_HOT_LL(P_HOT_LL),
    .TICKS_CRIT(P_CRIT), .TICKS_CRIT_LL(P_CRIT_LL), .TICKS_OPEN(P_OPEN),
    .TICKS_ARM(P_ARM), .TICKS_SHORT(P_SHORT), .TICKS_SOFT(P_SOFT)
  ) dut_i (.*);

  // kind: 0 over-voltage, 1 warning, 2 critical, 3 open loop, 4 shorted sense
  typedef struct packed {
    logic [2:0] kind;
    logic       ll;
    logic       mode;
    logic [7:0] n;
    logic [2:0] cause;
    logic       latched;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 1'b0, 1'b0, 8'(P_OV),            3'd1, 1'b1},
    '{3'd1, 1'b0, 1'b0, 8'(P_HOT),           3'd2, 1'b1},
    '{3'd1, 1'b1, 1'b0, 8'(P_HOT_LL),        3'd2, 1'b1},
    '{3'd2, 1'b0, 1'b0, 8'(P_CRIT),          3'd2, 1'b1},
    '{3'd2, 1'b1, 1'b0, 8'(P_CRIT_LL),       3'd2, 1'b1},
    '{3'd3, 1'b0, 1'b0, 8'(P_OPEN),          3'd4, 1'b0},
    '{3'd3, 1'b0, 1'b1, 8'(P_OPEN),          3'd4, 1'b1},
    '{3'd4, 1'b0, 1'b0, 8'(P_ARM + P_SHORT), 3'd3, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic supply(input logic on, input logic off, input logic snk, input logic rel);
    vdd_ge_on = on; vdd_ge_off = off; vdd_ge_sink = snk; vdd_ge_rel = rel;
  endtask

  task automatic set_fault(input logic [2:0] kind, input logic v);
    case (kind)
      3'd0: ovp_flag = v;
      3'd1: hot_warn_flag = v;
      3'd2: hot_crit_flag = v;
      3'd3: fb_high_flag = v;
      default: begin gate_on = v; sense_low_flag = v; end
    endcase
  endtask

  function automatic string req_of(input logic [2:0] kind);
    case (kind)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 reset pwm_en", pwm_en, 0);
    chk("R1 reset discharge_req", discharge_req, 0);
    chk("R1 reset soft_start", soft_start, 0);
    chk("R1 reset fault_cause", fault_cause, 0);
    rst_n = 1'b1;
    supply(0, 0, 0, 0);
    step(4);
    chk("R1 no start below turn-on", pwm_en, 0);

    // R10 soft-start window on first entry
    supply(1, 1, 1, 1);
    step(1);
    chk("R1 start at turn-on", pwm_en, 1);
    chk("R10 soft_start on entry", soft_start, 1);
    step(P_SOFT - 1);
    chk("R10 soft_start last tick", soft_start, 1);
    step(1);
    chk("R10 soft_start ends", soft_start, 0);

    // R7: interrupted over-voltage must restart its count
    ovp_flag = 1; step(P_OV - 1);
    ovp_flag = 0; step(1);
    ovp_flag = 1; step(P_OV - 1);
    chk("R7 broken debounce no trip", pwm_en, 1);
    ovp_flag = 0; step(1);
    chk("R7 cause untouched", fault_cause, 0);

    // R9 undervoltage while running
    supply(0, 0, 1, 1); step(1);
    chk("R9 discharge after uvlo", discharge_req, 1);
    chk("R9 pwm off after uvlo", pwm_en, 0);
    chk("R9 cause kept", fault_cause, 0);
    supply(0, 0, 0, 1); step(1);
    chk("R9 discharge stops at sink level", discharge_req, 0);
    supply(1, 1, 1, 1); step(1);
    chk("R9 restart at turn-on", pwm_en, 1);
    chk("R10 soft_start again", soft_start, 1);

    // R6: sense high at the sample point, low afterwards -> ignored
    gate_on = 1; sense_low_flag = 0; step(P_ARM);
    sense_low_flag = 1; step(P_SHORT + 5);
    chk("R6 low sense after sample ignored", pwm_en, 1);
    gate_on = 0; sense_low_flag = 0; step(1);

    // vector table
    foreach (VECS[i]) begin
      vec_t v;
      string r;
      v = VECS[i];
      r = req_of(v.kind);
      light_load = v.ll;
      open_loop_latch = v.mode;
      supply(1, 1, 1, 1); step(1);
      set_fault(v.kind, 1'b1);
      step(int'(v.n));
      chk({r, " running until qualified"}, pwm_en, 1);
      step(1);
      chk({r, " shutdown"}, pwm_en, 0);
      chk({r, " R11 cause code"}, fault_cause, int'(v.cause));
      set_fault(v.kind, 1'b0);
      chk({r, " no discharge right after trip"}, discharge_req, 0);
      if (v.latched) begin
        supply(0, 0, 0, 1); step(3);
        chk({r, " latched holds without discharge"}, discharge_req, 0);
        chk({r, " latched stays off"}, pwm_en, 0);
        supply(0, 0, 0, 0); step(1);
        supply(1, 1, 1, 1); step(1);
        chk({r, " restart after release"}, pwm_en, 1);
      end else begin
        supply(0, 0, 1, 1); step(1);
        chk({r, " R8 discharge below off"}, discharge_req, 1);
        chk({r, " R8 pwm stays off"}, pwm_en, 0);
        supply(0, 0, 0, 1); step(1);
        chk({r, " R8 discharge ends"}, discharge_req, 0);
        supply(1, 1, 1, 1); step(1);
        chk({r, " R8 restart at turn-on"}, pwm_en, 1);
      end
    end

    // R11 priority: over-voltage and critical qualify together
    light_load = 0;
    ovp_flag = 1; step(1);
    hot_crit_flag = 1; step(P_OV - 1);
    chk("R11 both pending still running", pwm_en, 1);
    step(1);
    chk("R11 over-voltage wins", fault_cause, 1);
    chk("R11 shutdown", pwm_en, 0);
    ovp_flag = 0; hot_crit_flag = 0;
    step(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule